// File: doc/BRIEF.md
# Dual-Port RAM with Collision Busy Flags

This block is a 2048-word by 8-bit memory with two fully independent ports, called left and right. Each port has its own enable, address, write strobe, write data and registered read data, and either port can read or write any word. When both ports are enabled on the same address in the same cycle, an arbiter picks one port to proceed and flags the other as busy. A busy port cannot write, but it can still read.

A role input sets how the busy pins behave. With the role input high, the block is a master: it runs its own arbitration and drives one busy flag per port. With the role input low, the block is a slave: it runs no arbitration, drives its busy outputs low, and treats a pair of busy inputs as write inhibits for the matching ports. A word wider than 8 bits is built from one master and one or more slaves on the same addresses. The master's busy outputs are wired to every slave's busy inputs, so all slices block the same side. Address and enable must settle one clock before the write strobe is raised, so that busy is valid before the write edge. Enable, address and busy are plain level signals. The block has no handshake, and each port completes one access per clock.

Top module: `dual_port_busy_ram`

## Requirements
- R1: Each port can write and read all 2048 locations. A read (enable high, write strobe low) returns the addressed word on that port's read data output one clock later. Read data resets to 0 and holds whenever no read is issued.
- R2: With the role input low, both busy outputs stay 0. A high busy input blocks writes from the matching port, and a low busy input allows them. With the role input high, the busy inputs have no effect.
- R3: In master mode, a busy output is high only when both enables are high and the two addresses are equal. The write strobes have no part in this decision.
- R4: The two busy outputs are never high in the same cycle.
- R5: When a collision starts on both ports in the same cycle (neither port was enabled on that address in the previous cycle), the right port is flagged busy and the left port proceeds.
- R6: A port that was already enabled on an address before the other port arrived keeps priority for as long as its enable stays high and its address does not change. If it changes address, the collision ends. If it then returns, the port that stayed becomes the holder.
- R7: A write from a busy or inhibited port is discarded. A write from the winning port is stored. With a master's busy outputs driving a slave's busy inputs, the same side is blocked in both byte slices of a shared word.
- R8: A busy port's reads still return the stored data.
- R9: When both ports write the same address on one clock edge and neither is inhibited, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = arbitrate and drive busy, 0 = take busy as write inhibit |
| l_ce | input | 1 | Left port enable |
| l_addr | input | 11 | Left port word address |
| l_we | input | 1 | Left port write strobe |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, one clock after the read |
| l_busy_i | input | 1 | Left write inhibit from a master (slave role only) |
| l_busy_o | output | 1 | Left busy flag (master role only) |
| r_ce | input | 1 | Right port enable |
| r_addr | input | 11 | Right port word address |
| r_we | input | 1 | Right port write strobe |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, one clock after the read |
| r_busy_i | input | 1 | Right write inhibit from a master (slave role only) |
| r_busy_o | output | 1 | Right busy flag (master role only) |

## Verification
The arbiter's only state is a copy of the last cycle's enables, addresses and winner. If that copy is wrong, busy lands on the wrong side during the first cycle of a collision, or during the first cycle after a holder moves away and comes back. The bench samples busy in exactly those cycles. A wrong winner, or a slave ignoring its inhibit, shows up as a changed byte in a 16-bit word that pairs a master with a slave. The bench reads that word back right after the collision ends. A fault in the storage or read path shows up in a full sweep of all addresses from each port. Every read result appears one clock after its request.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  // Which port won the current collision, if any.
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;

  localparam int PORT_L = 0;
  localparam int PORT_R = 1;
  localparam int N_PORTS = 2;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_l,
  input  logic              ce_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output win_e              win
);
  logic              ce_l_q, ce_r_q;
  logic [ADDR_W-1:0] addr_l_q, addr_r_q;
  win_e              win_q;
  logic              hold_l, hold_r, collide;

  always_comb begin
    collide = ce_l && ce_r && (addr_l == addr_r);
    hold_l  = ce_l_q && (addr_l_q == addr_l);
    hold_r  = ce_r_q && (addr_r_q == addr_r);
    if (!collide)                 win = WIN_NONE;
    else if (hold_l && hold_r)    win = (win_q == WIN_RIGHT) ? WIN_RIGHT : WIN_LEFT;
    else if (hold_r)              win = WIN_RIGHT;
    else                          win = WIN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_l_q   <= 1'b0;
      ce_r_q   <= 1'b0;
      addr_l_q <= '0;
      addr_r_q <= '0;
      win_q    <= WIN_NONE;
    end else begin
      ce_l_q   <= ce_l;
      ce_r_q   <= ce_r;
      addr_l_q <= addr_l;
      addr_r_q <= addr_r;
      win_q    <= win;
    end
  end
endmodule

// File: rtl/dpr_role.sv
module dpr_role
  import dpr_pkg::*;
(
  input  logic               is_master,
  input  logic [N_PORTS-1:0] arb_busy,
  input  logic [N_PORTS-1:0] ext_busy,
  output logic [N_PORTS-1:0] busy_out,
  output logic [N_PORTS-1:0] inhibit
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    always_comb begin
      busy_out[p] = is_master & arb_busy[p];
      inhibit[p]  = is_master ? arb_busy[p] : ext_busy[p];
    end
  end
endmodule

// File: rtl/dpr_store.sv
module dpr_store
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORTS-1:0]             wr_en,
  input  logic [N_PORTS-1:0]             rd_en,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wdata,
  output logic [N_PORTS-1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              same_word;
  logic              r_commit;

  always_comb begin
    same_word = addr[PORT_L] == addr[PORT_R];
    // Left data wins when both ports store to one word.
    r_commit  = wr_en[PORT_R] && !(wr_en[PORT_L] && same_word);
  end

  always_ff @(posedge clk) begin
    if (wr_en[PORT_L]) mem[addr[PORT_L]] <= wdata[PORT_L];
    if (r_commit)      mem[addr[PORT_R]] <= wdata[PORT_R];
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_en[p]) rdata[p] <= mem[addr[p]];
    end
  end
endmodule

// File: rtl/dual_port_busy_ram.sv
module dual_port_busy_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_i,
  output logic              r_busy_o
);
  win_e                           win;
  logic [N_PORTS-1:0]             arb_busy, ext_busy, busy_out, inhibit;
  logic [N_PORTS-1:0]             wr_en, rd_en;
  logic [N_PORTS-1:0][ADDR_W-1:0] addr_v;
  logic [N_PORTS-1:0][DATA_W-1:0] wdata_v, rdata_v;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_l   (l_ce),
    .ce_r   (r_ce),
    .addr_l (l_addr),
    .addr_r (r_addr),
    .win    (win)
  );

  always_comb begin
    arb_busy[PORT_L] = (win == WIN_RIGHT);
    arb_busy[PORT_R] = (win == WIN_LEFT);
    ext_busy[PORT_L] = l_busy_i;
    ext_busy[PORT_R] = r_busy_i;
    addr_v[PORT_L]   = l_addr;
    addr_v[PORT_R]   = r_addr;
    wdata_v[PORT_L]  = l_wdata;
    wdata_v[PORT_R]  = r_wdata;
    wr_en[PORT_L]    = l_ce && l_we && !inhibit[PORT_L];
    wr_en[PORT_R]    = r_ce && r_we && !inhibit[PORT_R];
    rd_en[PORT_L]    = l_ce && !l_we;
    rd_en[PORT_R]    = r_ce && !r_we;
    l_busy_o         = busy_out[PORT_L];
    r_busy_o         = busy_out[PORT_R];
    l_rdata          = rdata_v[PORT_L];
    r_rdata          = rdata_v[PORT_R];
  end

  dpr_role u_role (
    .is_master (is_master),
    .arb_busy  (arb_busy),
    .ext_busy  (ext_busy),
    .busy_out  (busy_out),
    .inhibit   (inhibit)
  );

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rdata (rdata_v)
  );
endmodule

// File: rtl/dual_port_busy_ram_chk.sv
module dual_port_busy_ram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              l_ce,
  input logic              r_ce,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_o,
  input logic              r_busy_o
);
  logic clash;
  assign clash = l_ce && r_ce && (l_addr == r_addr);

  // R4
  one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_o && r_busy_o));

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_o || r_busy_o) |-> (is_master && clash));

  // R3
  clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && clash) |-> (l_busy_o || r_busy_o));

  // R2
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!l_busy_o && !r_busy_o));

  // R5
  fresh_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && clash && !$past(l_ce) && !$past(r_ce)) |-> r_busy_o);

  // R6
  left_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy_o ##1 (is_master && clash && $stable(l_addr) && $stable(r_addr)) |-> r_busy_o);

  // R6
  right_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_o ##1 (is_master && clash && $stable(l_addr) && $stable(r_addr)) |-> l_busy_o);
endmodule

bind dual_port_busy_ram dual_port_busy_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .l_ce      (l_ce),
  .r_ce      (r_ce),
  .l_addr    (l_addr),
  .r_addr    (r_addr),
  .l_busy_o  (l_busy_o),
  .r_busy_o  (r_busy_o)
);

// File: tb/dual_port_busy_ram_bench.sv
module dual_port_busy_ram_bench;
  localparam int AW = 11;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          l_ce = 0, r_ce = 0, l_we = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [15:0]   l_wd = '0, r_wd = '0;
  logic          link_en = 1, force_l = 0, m_l_in = 0;
  logic [7:0]    ml_rd, mr_rd, sl_rd, sr_rd;
  logic          m_lb, m_rb, s_lb, s_rb;
  logic          s_l_in, s_r_in;
  int            n_vec = 0, n_bad = 0;

  assign s_l_in = link_en ? m_lb : force_l;
  assign s_r_in = link_en ? m_rb : 1'b0;

  dual_port_busy_ram u_dual_port_busy_ram (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1),
    .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wd[7:0]), .l_rdata(ml_rd),
    .l_busy_i(m_l_in), .l_busy_o(m_lb),
    .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wd[7:0]), .r_rdata(mr_rd),
    .r_busy_i(1'b0), .r_busy_o(m_rb)
  );

  dual_port_busy_ram u_dual_port_busy_ram_hi (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0),
    .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wd[15:8]), .l_rdata(sl_rd),
    .l_busy_i(s_l_in), .l_busy_o(s_lb),
    .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wd[15:8]), .r_rdata(sr_rd),
    .r_busy_i(s_r_in), .r_busy_o(s_rb)
  );

  function automatic logic [15:0] pat_a(input int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction
  function automatic logic [15:0] pat_b(input int a);
    return {8'(a[7:0] ^ 8'hA5), 8'(~a[10:3])};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    l_ce = 0; r_ce = 0; l_we = 0; r_we = 0;
  endtask

  task automatic wr(input bit right, input int a, input logic [15:0] d);
    @(negedge clk);
    if (right) begin r_ce = 1; r_addr = AW'(a); r_we = 0; end
    else       begin l_ce = 1; l_addr = AW'(a); l_we = 0; end
    @(negedge clk);
    if (right) begin r_we = 1; r_wd = d; end
    else       begin l_we = 1; l_wd = d; end
    @(negedge clk);
    l_we = 0; r_we = 0; l_ce = 0; r_ce = 0;
  endtask

  task automatic rd(input bit right, input int a, input logic [15:0] exp, input string req);
    @(negedge clk);
    if (right) begin r_ce = 1; r_addr = AW'(a); r_we = 0; end
    else       begin l_ce = 1; l_addr = AW'(a); l_we = 0; end
    @(negedge clk); #1;
    if (right) chk(req, {16'h0, sr_rd, mr_rd}, {16'h0, exp});
    else       chk(req, {16'h0, sl_rd, ml_rd}, {16'h0, exp});
    l_ce = 0; r_ce = 0;
  endtask

  // Right port takes word a first, then left arrives on it.
  task automatic right_holds(input int a);
    @(negedge clk); r_ce = 1; r_addr = AW'(a); r_we = 0;
    @(negedge clk); l_ce = 1; l_addr = AW'(a); l_we = 0; #1;
    chk("R6 holder right: left busy", {30'h0, m_lb, m_rb}, 32'h2);
    chk("R2 slave busy outputs low", {30'h0, s_lb, s_rb}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset rdata", {ml_rd, mr_rd, sl_rd, sr_rd}, 32'h0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R3 idle busy low", {28'h0, m_lb, m_rb, s_lb, s_rb}, 32'h0);

    // R1: full sweeps, each port writes, the other reads.
    for (int a = 0; a < NW; a++) wr(0, a, pat_a(a));
    for (int a = 0; a < NW; a++) rd(1, a, pat_a(a), "R1 left write/right read");
    for (int a = 0; a < NW; a++) wr(1, a, pat_b(a));
    for (int a = 0; a < NW; a++) rd(0, a, pat_b(a), "R1 right write/left read");

    // R3: distinct addresses, both enabled, with writes, no busy.
    @(negedge clk); l_ce = 1; r_ce = 1; l_addr = 11'd10; r_addr = 11'd11; #1;
    chk("R3 distinct addr no busy", {30'h0, m_lb, m_rb}, 32'h0);
    @(negedge clk); l_we = 1; r_we = 1; #1;
    chk("R3 strobes do not cause busy", {30'h0, m_lb, m_rb}, 32'h0);
    idle();

    // R5 / R3: fresh collision with reads only; right busy.
    @(negedge clk); l_ce = 1; r_ce = 1; l_addr = 11'd42; r_addr = 11'd42; #1;
    chk("R5 fresh collision right busy", {30'h0, m_lb, m_rb}, 32'h1);
    @(negedge clk); #1;
    chk("R6 left keeps priority", {30'h0, m_lb, m_rb}, 32'h1);
    chk("R8 busy right still reads", {16'h0, sr_rd, mr_rd}, {16'h0, pat_b(42)});
    idle(); idle();

    // R7: right holds, left's write blocked in both slices.
    right_holds(500);
    @(negedge clk); l_we = 1; l_wd = 16'hBEEF;
    @(negedge clk); l_we = 0; #1;
    chk("R6 right still holds", {30'h0, m_lb, m_rb}, 32'h2);
    @(negedge clk); #1;
    chk("R8 busy left reads data", {16'h0, sl_rd, ml_rd}, {16'h0, pat_b(500)});
    idle(); idle();
    rd(1, 500, pat_b(500), "R7 blocked write discarded both halves");

    // R7: winner (right) write during collision is stored.
    right_holds(600);
    @(negedge clk); r_we = 1; r_wd = 16'h7A3C;
    @(negedge clk); r_we = 0;
    idle(); idle();
    rd(0, 600, 16'h7A3C, "R7 winner write stored");

    // R6: holder moves away and returns; left becomes holder.
    right_holds(800);
    @(negedge clk); r_addr = 11'd801; #1;
    chk("R6 move away clears busy", {30'h0, m_lb, m_rb}, 32'h0);
    @(negedge clk); r_addr = 11'd800; #1;
    chk("R6 left now holder, right busy", {30'h0, m_lb, m_rb}, 32'h1);
    idle(); idle();

    // R9: both write same word, slave not inhibited; left data stored.
    link_en = 0;
    @(negedge clk); l_ce = 1; r_ce = 1; l_addr = 11'd300; r_addr = 11'd300;
    @(negedge clk); l_we = 1; r_we = 1; l_wd = 16'hC3A1; r_wd = 16'h1E7F;
    @(negedge clk); l_we = 0; r_we = 0;
    idle(); idle();
    rd(0, 300, 16'hC3A1, "R9 both write, left stored");

    // R2: master ignores its busy input; slave obeys a forced inhibit.
    m_l_in = 1;
    wr(0, 700, 16'h0F0F);
    rd(1, 700, 16'h0F0F, "R2 master ignores busy input");
    m_l_in = 0;
    force_l = 1;
    wr(0, 700, 16'h2222);
    rd(1, 700, 16'h0F22, "R2 slave inhibit blocks high byte");
    force_l = 0;
    wr(0, 700, 16'h5566);
    rd(1, 700, 16'h5566, "R2 slave low inhibit allows write");
    link_en = 1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule